// File: doc/BRIEF.md
# PWM Period Timer with Postscaled Interrupt

This block is the period time base for a pulse-width modulator. A 12-bit timer advances on prescaled ticks of the cycle clock. It either counts up and wraps to zero after reaching the period value, which suits edge-aligned PWM, or it counts up to the period value and then back down to zero, which suits center-aligned PWM. Each arrival at the period value is a match event. The match events pass through a programmable postscaler, and the postscaler sets a sticky interrupt flag that software clears.

Software reaches the block through three write ports: the timer value, the period value and a control word. The control word holds an enable bit, a counting mode, a prescale selection and a postscale ratio. The outputs show the current timer value, the counting direction, a match pulse and the interrupt flag.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the timer reads 0, the interrupt flag, the down indication and the match output are 0, the block is disabled and the period register holds 0xFFF.
- R2: The control word is {enable at bit 8, mode at bits 7:6, prescale select at bits 5:4, postscale select at bits 3:0}. While enable is 0, the timer, the prescaler and the postscaler hold their values.
- R3: Prescale select 0, 1, 2 or 3 makes the timer advance once every 1, 4, 16 or 64 enabled cycles. A timer write or a reset clears the prescale count, so the first advance after a timer write comes one full interval later.
- R4: In free-running mode (any mode value other than 2'b10) the timer counts up. On a tick where the timer is at or above the period value, match_o is high for that cycle and the timer becomes 0 at that edge.
- R5: In up/down mode (mode 2'b10) the timer counts from 0 up to the period value and then back down to 0, repeating every 2×period ticks. match_o is high on the tick that leaves the top, and dir_down is 1 while counting down. In free-running mode dir_down is 0.
- R6: With postscale select N, the interrupt flag sets on every (N+1)-th match event.
- R7: A timer write or a control write clears the postscale count. A match in the same cycle as the write is not counted.
- R8: A control write does not change the timer value.
- R9: The interrupt flag stays set until irq_clr is pulsed. If a postscaled match occurs in the same cycle as the clear, the flag stays set.
- R10: With a period value of 0, the timer stays at 0 and match_o is high on every prescaled tick.
- R11: A timer write loads the value at the next edge, even while the block is disabled. It takes priority over counting and sets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 12 | Timer write value |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 12 | Period write value |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word |
| irq_clr | input | 1 | Interrupt flag clear pulse |
| tmr_o | output | 12 | Current timer value |
| dir_down | output | 1 | 1 while counting down |
| match_o | output | 1 | Match event pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions check the rules that hold on every single cycle:
- the timer holds while the block is disabled;
- a control write leaves the timer alone;
- a free-running wrap goes to zero;
- a period of 0 stays at zero;
- timer writes load and clear the prescale and postscale counts;
- the flag is sticky and a set wins over a clear.

Other behaviour only shows over many cycles, so the bench scenarios cover it:
- the division ratios of the prescaler;
- the triangle shape and the down indication in up/down mode;
- the (N+1)-th match interval of the postscaler;
- the delayed interrupt after a control write restarts the postscale count.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    localparam int PRE_SEL_W  = 2;
    localparam int PRE_STEP   = 2;
    localparam int POST_SEL_W = 4;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'b00,
        MODE_RSV1  = 2'b01,
        MODE_UPDN  = 2'b10,
        MODE_RSV3  = 2'b11
    } mode_e;

    typedef struct packed {
        logic                   en;
        mode_e                  mode;
        logic [PRE_SEL_W-1:0]   pre;
        logic [POST_SEL_W-1:0]  post;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
    parameter int SEL_W = 2,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = STEP * ((1 << SEL_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              s_d, s_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = '0;
        for (int i = 0; i < (1 << SEL_W); i++) begin
            if (sel == SEL_W'(i)) last = CNT_W'((1 << (STEP * i)) - 1);
        end
        tick = en && (s_q.cnt >= last);
        s_d  = s_q;
        if (clr)       s_d.cnt = '0;
        else if (tick) s_d.cnt = '0;
        else if (en)   s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0)); // R3
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(s_q.cnt)); // R2
endmodule

// File: rtl/ptb_postscaler.sv
module ptb_postscaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         evt,
    input  logic [W-1:0] ratio,
    output logic         fire
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        fire = evt && !clr && (s_q.cnt >= ratio);
        s_d  = s_q;
        if (clr)       s_d.cnt = '0;
        else if (fire) s_d.cnt = '0;
        else if (evt)  s_d.cnt = s_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_POST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0)); // R7
    AST_POST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr) |=> $stable(s_q.cnt)); // R2
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         updn,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] per,
    output logic [W-1:0] tmr,
    output logic         down,
    output logic         match
);
    typedef struct packed {
        logic [W-1:0] tmr;
        logic         down;
    } st_t;

    st_t  s_d, s_q;
    logic at_top;

    always_comb begin
        s_d    = s_q;
        match  = 1'b0;
        at_top = (s_q.tmr >= per);
        if (tick) begin
            if (!updn) begin
                if (at_top) begin
                    match   = 1'b1;
                    s_d.tmr = '0;
                end else begin
                    s_d.tmr = s_q.tmr + W'(1);
                end
            end else if (!s_q.down) begin
                if (at_top) begin
                    match = 1'b1;
                    if (per == '0) begin
                        s_d.tmr = '0;
                    end else begin
                        s_d.tmr  = s_q.tmr - W'(1);
                        s_d.down = 1'b1;
                    end
                end else begin
                    s_d.tmr = s_q.tmr + W'(1);
                end
            end else begin
                if (s_q.tmr == '0) begin
                    s_d.down = 1'b0;
                    s_d.tmr  = (per == '0) ? '0 : W'(1);
                end else begin
                    s_d.tmr = s_q.tmr - W'(1);
                end
            end
        end
        if (!updn) s_d.down = 1'b0;
        if (wr) begin
            s_d.tmr  = wdata;
            s_d.down = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tmr  = s_q.tmr;
    assign down = s_q.down;

    AST_UPDN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && updn && s_q.down && s_q.tmr == '0 && !wr) |=> !s_q.down); // R5
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int TMR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             per_wr,
    input  logic [TMR_W-1:0] per_wdata,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             irq_clr,
    output logic [TMR_W-1:0] tmr_o,
    output logic             dir_down,
    output logic             match_o,
    output logic             irq_o
);
    typedef struct packed {
        ctl_t             ctl;
        logic [TMR_W-1:0] per;
        logic             irq;
    } st_t;

    st_t  s_d, s_q;
    logic tick;
    logic post_fire;
    logic updn;

    assign updn = (s_q.ctl.mode == MODE_UPDN);

    ptb_prescaler #(
        .SEL_W (PRE_SEL_W),
        .STEP  (PRE_STEP)
    ) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s_q.ctl.en),
        .clr   (tmr_wr),
        .sel   (s_q.ctl.pre),
        .tick  (tick)
    );

    ptb_counter #(
        .W (TMR_W)
    ) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .updn  (updn),
        .wr    (tmr_wr),
        .wdata (tmr_wdata),
        .per   (s_q.per),
        .tmr   (tmr_o),
        .down  (dir_down),
        .match (match_o)
    );

    ptb_postscaler #(
        .W (POST_SEL_W)
    ) i_post (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_wr || ctl_wr),
        .evt   (match_o),
        .ratio (s_q.ctl.post),
        .fire  (post_fire)
    );

    always_comb begin
        s_d = s_q;
        if (ctl_wr)         s_d.ctl = ctl_t'(ctl_wdata);
        if (per_wr)         s_d.per = per_wdata;
        if (post_fire)      s_d.irq = 1'b1;
        else if (irq_clr)   s_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.per <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o = s_q.irq;

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctl.en && !tmr_wr) |=> $stable(tmr_o)); // R2
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !updn && tmr_o >= s_q.per && !tmr_wr) |=> (tmr_o == '0)); // R4
    AST_DIR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !updn |=> !dir_down); // R5
    AST_CTL_KEEPS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !tmr_wr && !tick) |=> $stable(tmr_o)); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr) |=> irq_o); // R9
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        post_fire |=> irq_o); // R9
    AST_PER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.per == '0 && tmr_o == '0 && !tmr_wr) |=> (tmr_o == '0)); // R10
    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> (tmr_o == $past(tmr_wdata) && !dir_down)); // R11
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
    localparam int TW = 12;
    localparam int CW = 9;
    localparam int WDOG_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tmr_wr = 1'b0;
    logic [TW-1:0] tmr_wdata = '0;
    logic          per_wr = 1'b0;
    logic [TW-1:0] per_wdata = '0;
    logic          ctl_wr = 1'b0;
    logic [CW-1:0] ctl_wdata = '0;
    logic          irq_clr = 1'b0;
    logic [TW-1:0] tmr_o;
    logic          dir_down, match_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_timebase i_pwm_timebase (
        .clk(clk), .rst_n(rst_n),
        .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .irq_clr(irq_clr),
        .tmr_o(tmr_o), .dir_down(dir_down), .match_o(match_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  pre;
        logic [11:0] per;
        logic [15:0] n;
        logic [11:0] exp_tmr;
        logic        exp_dir;
        logic        exp_match;
    } vec_t;

    // mode 2'b00 free-running, 2'b10 up/down; pre 0..3 = 1:1,1:4,1:16,1:64
    localparam vec_t VECS [10] = '{
        '{2'b00, 2'd0, 12'd10,  16'd7,   12'd7, 1'b0, 1'b0},  // R4
        '{2'b00, 2'd0, 12'd10,  16'd13,  12'd2, 1'b0, 1'b0},  // R4 wrap
        '{2'b00, 2'd1, 12'd5,   16'd30,  12'd1, 1'b0, 1'b0},  // R3 1:4
        '{2'b00, 2'd2, 12'd3,   16'd70,  12'd0, 1'b0, 1'b0},  // R3 1:16
        '{2'b00, 2'd3, 12'd100, 16'd200, 12'd3, 1'b0, 1'b0},  // R3 1:64
        '{2'b10, 2'd0, 12'd4,   16'd6,   12'd2, 1'b1, 1'b0},  // R5 down
        '{2'b10, 2'd0, 12'd4,   16'd3,   12'd3, 1'b0, 1'b0},  // R5 up
        '{2'b10, 2'd1, 12'd3,   16'd20,  12'd1, 1'b1, 1'b0},  // R5 1:4
        '{2'b10, 2'd0, 12'd4,   16'd4,   12'd4, 1'b0, 1'b1},  // R5 top
        '{2'b00, 2'd0, 12'd0,   16'd5,   12'd0, 1'b0, 1'b1}   // R10
    };

    function automatic logic [CW-1:0] cw(input logic en, input logic [1:0] m,
                                         input logic [1:0] p, input logic [3:0] q);
        return {en, m, p, q};
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [CW-1:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step(1);
        ctl_wr = 1'b0;
    endtask

    task automatic per_write(input logic [TW-1:0] v);
        per_wr = 1'b1; per_wdata = v;
        step(1);
        per_wr = 1'b0;
    endtask

    task automatic tmr_write(input logic [TW-1:0] v, input logic clr);
        tmr_wr = 1'b1; tmr_wdata = v; irq_clr = clr;
        step(1);
        tmr_wr = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
    endtask

    task automatic prepare(input logic [1:0] m, input logic [1:0] p,
                           input logic [3:0] q, input logic [TW-1:0] per);
        ctl_write(cw(1'b0, m, p, q));
        per_write(per);
        tmr_write('0, 1'b1);
        ctl_write(cw(1'b1, m, p, q));
    endtask

    initial begin
        logic [TW-1:0] held;
        step(3);
        // R1 reset state
        check("R1 tmr", int'(tmr_o), 0);
        check("R1 irq", int'(irq_o), 0);
        check("R1 dir", int'(dir_down), 0);
        check("R1 match", int'(match_o), 0);
        rst_n = 1'b1;
        step(5);
        check("R1 disabled holds", int'(tmr_o), 0);

        // vector table
        foreach (VECS[k]) begin
            prepare(VECS[k].mode, VECS[k].pre, 4'd0, VECS[k].per);
            step(int'(VECS[k].n));
            check($sformatf("R3/R4/R5/R10 vec%0d tmr", k), int'(tmr_o), int'(VECS[k].exp_tmr));
            check($sformatf("R5 vec%0d dir", k), int'(dir_down), int'(VECS[k].exp_dir));
            check($sformatf("R4/R10 vec%0d match", k), int'(match_o), int'(VECS[k].exp_match));
        end

        // R4 match pulse and wrap
        prepare(2'b00, 2'd0, 4'd0, 12'd3);
        step(3);
        check("R4 at top", int'(tmr_o), 3);
        check("R4 match high", int'(match_o), 1);
        step(1);
        check("R4 wrapped", int'(tmr_o), 0);
        check("R4 match low", int'(match_o), 0);

        // R3 full interval after timer write
        prepare(2'b00, 2'd1, 4'd0, 12'hFFF);
        step(9);
        check("R3 two ticks", int'(tmr_o), 2);
        tmr_write(12'd50, 1'b0);
        step(3);
        check("R3 no early tick", int'(tmr_o), 50);
        step(1);
        check("R3 tick after interval", int'(tmr_o), 51);

        // R2 hold when disabled, R11 write while disabled
        ctl_write(cw(1'b0, 2'b00, 2'd0, 4'd0));
        held = tmr_o;
        step(10);
        check("R2 hold", int'(tmr_o), int'(held));
        tmr_write(12'd77, 1'b0);
        check("R11 write disabled", int'(tmr_o), 77);
        step(5);
        check("R2 hold after write", int'(tmr_o), 77);

        // R8 control write keeps timer
        ctl_write(cw(1'b1, 2'b00, 2'd0, 4'd0));
        check("R8 timer kept", int'(tmr_o), 77);
        step(1);
        check("R8 counts on", int'(tmr_o), 78);

        // R11 timer write in up/down sets direction up
        prepare(2'b10, 2'd0, 4'd0, 12'd4);
        step(6);
        check("R5 down before write", int'(dir_down), 1);
        tmr_write(12'd2, 1'b0);
        check("R11 loaded", int'(tmr_o), 2);
        check("R11 dir up", int'(dir_down), 0);
        step(1);
        check("R11 counts up", int'(tmr_o), 3);

        // R6 postscaler 1:3
        prepare(2'b00, 2'd0, 4'd2, 12'd1);
        step(5);
        check("R6 irq not yet", int'(irq_o), 0);
        step(1);
        check("R6 irq on third match", int'(irq_o), 1);

        // R7 control write restarts postscale count
        prepare(2'b00, 2'd0, 4'd2, 12'd1);
        step(4);
        ctl_write(cw(1'b1, 2'b00, 2'd0, 4'd2));
        step(4);
        check("R7 irq delayed", int'(irq_o), 0);
        step(1);
        check("R7 irq after restart", int'(irq_o), 1);

        // R9 sticky and clear
        step(3);
        check("R9 sticky", int'(irq_o), 1);
        clear_irq();
        check("R9 cleared", int'(irq_o), 0);

        // R9 set wins over clear, R10 match every tick
        prepare(2'b00, 2'd0, 4'd0, 12'd0);
        step(2);
        check("R9 irq set", int'(irq_o), 1);
        clear_irq();
        check("R9 set wins", int'(irq_o), 1);
        check("R10 timer zero", int'(tmr_o), 0);
        check("R10 match", int'(match_o), 1);
        ctl_write(cw(1'b0, 2'b00, 2'd0, 4'd0));
        clear_irq();
        check("R9 clear when idle", int'(irq_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < WDOG_CYC; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule